// File: doc/BRIEF.md
# Transposed-Form Constant FIR Filter

This block is a streaming four-tap FIR filter with fixed coefficients. Every accepted 12-bit signed sample enters one shared constant multiplier that is built only from shifts and add/subtract operations. That multiplier is pipelined over three register stages. Its four tap products then feed a transposed chain of structural adders. Each delay register in that chain is also the pipeline register of the adder in front of it, so the chain adds no logic depth beyond a single adder.

The tap weights are h[0]=480, h[1]=512, h[2]=846 and h[3]=1020. The multiplier derives them from four odd fundamentals: 15, 47, 255 and 423. The fundamental 15 is recomputed in the last stage rather than carried through a register. The result is never rounded, so the output width is derived from the input width and the sum of the coefficient magnitudes, which gives 24 bits at the default input width. Both the input and the output are registered. The delay chain moves only when a product set marked valid leaves the multiplier. Cycles without a sample therefore leave the filter history untouched.

Top module: `fir_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `out_data` is 0. Reset clears the delay chain, so the first outputs treat every earlier sample as zero.
- R2: For accepted samples x[n], the output stream is y[n] = 480·x[n] + 512·x[n-1] + 846·x[n-2] + 1020·x[n-3], and it is exact.
- R3: A sample accepted at a rising edge (in_valid high) appears with `out_valid` high for exactly one cycle, five rising edges later. The latency is the same under any pattern of valid and idle cycles.
- R4: Every accepted sample produces one output, and `out_valid` never rises without a matching accepted sample.
- R5: When `in_valid` is low, `in_data` is ignored and the filter history does not advance.
- R6: While `out_valid` is low, `out_data` keeps its last value.
- R7: Full-scale inputs of +2047 and -2048 give exact results within ±5,853,184, carried in a 24-bit two's-complement output.
- R8: A single sample of 1 followed by zeros produces 480, 512, 846, 1020 and then 0, in that order.
- R9: Samples may arrive on every cycle with no idle gap, and each one is still filtered correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a new sample this cycle |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | Marks `out_data` as a new filter result |
| out_data | output | 24 | Signed full-precision filter result |

## Verification
The hard case is the same clock edge on which the output adder consumes the first delay register and every delay register reloads from its neighbour and a fresh product. Long back-to-back bursts of full-scale and alternating-sign samples provoke this case. Idle gaps are a second case: the chain must stay frozen while the free-running multiplier pipeline still carries earlier samples and the input lines carry random junk. A scoreboard keeps an independent model of the accepted-sample history. It judges every output on its value and on its cycle stamp, and between results it checks that the output holds still.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;

  // Tap count and coefficient magnitudes (h[0] is the newest sample)
  localparam int TAPS = 4;
  localparam int COEF [TAPS] = '{480, 512, 846, 1020};

  // Register stages of the shared constant multiplier
  localparam int MCM_STAGES = 3;

  // Input register + multiplier stages + output register
  localparam int LATENCY = MCM_STAGES + 2;

  function automatic int coef_sum();
    int s;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += COEF[k];
    return s;
  endfunction

  // Width that holds the full-precision worst case for a given input width
  function automatic int out_width(int iw);
    longint peak;
    peak = longint'(coef_sum()) << (iw - 1);
    return $clog2(peak) + 1;
  endfunction

endpackage

// File: rtl/fir_mcm_pipe.sv
`timescale 1ns/1ps
// Pipelined shift-and-add block producing all four tap products.
// Stage 1: x, 15x            (15 = 16 - 1)
// Stage 2: x, 47x            (47 = 32 + 15)
// Stage 3: x, 15x, 255x, 423x (15 recomputed, 255 = 256 - 1, 423 = 8*47 + 47)
// Products are even multiples taken by wiring: 480=15<<5, 512=1<<9,
// 846=423<<1, 1020=255<<2.
module fir_mcm_pipe #(
  parameter int IN_W   = 12,
  parameter int PROD_W = 24,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic signed [IN_W-1:0]   x_i,
  output logic                     vld_o,
  output logic signed [PROD_W-1:0] prod_o [TAPS]
);
  import fir_pkg::*;

  localparam int W15  = IN_W + 4;
  localparam int W47  = IN_W + 6;
  localparam int W255 = IN_W + 8;
  localparam int W423 = IN_W + 9;

  // ---------------- stage 1 ----------------
  logic signed [W15-1:0]  s1_xe, s1_f15;
  logic signed [IN_W-1:0] r1_x;
  logic signed [W15-1:0]  r1_f15;

  assign s1_xe  = W15'(x_i);
  assign s1_f15 = (s1_xe <<< 4) - s1_xe;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_x   <= '0;
      r1_f15 <= '0;
    end else begin
      r1_x   <= x_i;
      r1_f15 <= s1_f15;
    end
  end

  // ---------------- stage 2 ----------------
  logic signed [W47-1:0]  s2_xe, s2_f15e, s2_f47;
  logic signed [IN_W-1:0] r2_x;
  logic signed [W47-1:0]  r2_f47;

  assign s2_xe   = W47'(r1_x);
  assign s2_f15e = W47'(r1_f15);
  assign s2_f47  = (s2_xe <<< 5) + s2_f15e;

  always_ff @(posedge clk) begin
    if (rst) begin
      r2_x   <= '0;
      r2_f47 <= '0;
    end else begin
      r2_x   <= r1_x;
      r2_f47 <= s2_f47;
    end
  end

  // ---------------- stage 3 ----------------
  logic signed [W15-1:0]  s3_x15, s3_f15;
  logic signed [W255-1:0] s3_x255, s3_f255;
  logic signed [W423-1:0] s3_f47e, s3_f423;
  logic signed [IN_W-1:0] r3_x;
  logic signed [W15-1:0]  r3_f15;
  logic signed [W255-1:0] r3_f255;
  logic signed [W423-1:0] r3_f423;

  assign s3_x15  = W15'(r2_x);
  assign s3_f15  = (s3_x15 <<< 4) - s3_x15;
  assign s3_x255 = W255'(r2_x);
  assign s3_f255 = (s3_x255 <<< 8) - s3_x255;
  assign s3_f47e = W423'(r2_f47);
  assign s3_f423 = (s3_f47e <<< 3) + s3_f47e;

  always_ff @(posedge clk) begin
    if (rst) begin
      r3_x    <= '0;
      r3_f15  <= '0;
      r3_f255 <= '0;
      r3_f423 <= '0;
    end else begin
      r3_x    <= r2_x;
      r3_f15  <= s3_f15;
      r3_f255 <= s3_f255;
      r3_f423 <= s3_f423;
    end
  end

  // ---------------- wired shifts to tap products ----------------
  logic signed [PROD_W-1:0] e_f15, e_x, e_f423, e_f255;

  assign e_f15  = PROD_W'(r3_f15);
  assign e_x    = PROD_W'(r3_x);
  assign e_f423 = PROD_W'(r3_f423);
  assign e_f255 = PROD_W'(r3_f255);

  assign prod_o[0] = e_f15  <<< 5;
  assign prod_o[1] = e_x    <<< 9;
  assign prod_o[2] = e_f423 <<< 1;
  assign prod_o[3] = e_f255 <<< 2;

  // ---------------- valid alignment ----------------
  logic [MCM_STAGES-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[MCM_STAGES-2:0], vld_i};
  end

  assign vld_o = vpipe[MCM_STAGES-1];

endmodule

// File: rtl/fir_tap_chain.sv
`timescale 1ns/1ps
// Transposed structural adder chain. dly[k] holds the partial sum that
// the adder for tap k consumes; it is also that adder's pipeline register.
module fir_tap_chain #(
  parameter int TAPS  = 4,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] prod_i [TAPS],
  output logic signed [ACC_W-1:0] sum_o
);

  localparam int NDLY = TAPS - 1;

  logic signed [ACC_W-1:0] dly  [NDLY];
  logic signed [ACC_W-1:0] nxt  [NDLY];

  // Far end takes the oldest-tap product alone; every other delay adds its
  // product to the partial sum arriving from farther down the chain.
  generate
    for (genvar k = 0; k < NDLY; k++) begin : g_link
      if (k == NDLY - 1) begin : g_far
        assign nxt[k] = prod_i[k+1];
      end else begin : g_mid
        assign nxt[k] = prod_i[k+1] + dly[k+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NDLY; k++) dly[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NDLY; k++) dly[k] <= nxt[k];
    end
  end

  assign sum_o = prod_i[0] + dly[0];

endmodule

// File: rtl/fir_top.sv
`timescale 1ns/1ps
module fir_top #(
  parameter  int IN_W  = 12,
  localparam int OUT_W = fir_pkg::out_width(IN_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import fir_pkg::*;

  // Input register
  logic                   in_vld_q;
  logic signed [IN_W-1:0] in_dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_vld_q <= 1'b0;
      in_dat_q <= '0;
    end else begin
      in_vld_q <= in_valid;
      in_dat_q <= in_data;
    end
  end

  // Shared constant multiplier
  logic                    prod_vld;
  logic signed [OUT_W-1:0] prod [TAPS];

  fir_mcm_pipe #(
    .IN_W   (IN_W),
    .PROD_W (OUT_W),
    .TAPS   (TAPS)
  ) u_mcm (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (in_vld_q),
    .x_i    (in_dat_q),
    .vld_o  (prod_vld),
    .prod_o (prod)
  );

  // Structural adders with delay registers
  logic signed [OUT_W-1:0] chain_sum;

  fir_tap_chain #(
    .TAPS  (TAPS),
    .ACC_W (OUT_W)
  ) u_chain (
    .clk    (clk),
    .rst    (rst),
    .en     (prod_vld),
    .prod_i (prod),
    .sum_o  (chain_sum)
  );

  // Output register, held between results
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= prod_vld;
      if (prod_vld) out_data <= chain_sum;
    end
  end

endmodule

// File: rtl/fir_top_chk.sv
`timescale 1ns/1ps
module fir_top_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  import fir_pkg::*;

  localparam int CW = $clog2(LATENCY + 1);
  localparam longint PEAK = longint'(coef_sum()) << (IN_W - 1);
  localparam logic signed [OUT_W-1:0] HI = OUT_W'(PEAK);
  localparam logic signed [OUT_W-1:0] LO = -HI;

  // Cycles since reset, saturating at the latency
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(LATENCY)) since_rst <= since_rst + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CW'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY))); // R3

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_rst != CW'(LATENCY)) |-> !out_valid); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R6

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= HI && out_data >= LO)); // R7

endmodule

bind fir_top fir_top_chk #(
  .IN_W  (IN_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_fir_top.sv
`timescale 1ns/1ps
module sim_fir_top;

  localparam int IW   = 12;
  localparam int OW   = 24;
  localparam int NT   = 4;
  localparam int LAT  = 5;
  localparam int H [NT] = '{480, 512, 846, 1020};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [IW-1:0] in_data = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_data;

  fir_top #(.IN_W(IW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #2 clk = ~clk;

  typedef struct {
    longint val;
    int     stamp;
    string  tag;
  } exp_t;

  exp_t   sb [$];
  longint hist [NT];
  int     cyc = 0;
  int     checks = 0;
  int     errors = 0;
  int     n_in = 0;
  int     n_out = 0;
  logic signed [OW-1:0] last_out = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: one accepted sample, expected result pushed to the scoreboard
  task automatic push(input int v, input string tag);
    longint e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = IW'(v);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(v);
    e = 0;
    for (int k = 0; k < NT; k++) e += longint'(H[k]) * hist[k];
    sb.push_back('{e, cyc, tag});
    n_in++;
  endtask

  // Idle cycles with junk on the data lines (R5)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = IW'($urandom);
    end
  endtask

  // Monitor: pop and compare, check stamp and idle hold
  always @(negedge clk) begin
    exp_t it;
    if (!rst) begin
      if (out_valid) begin
        n_out++;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R4: output %0d with no pending sample, expected none", out_data);
        end else begin
          it = sb.pop_front();
          if (longint'(out_data) != it.val) begin
            errors++;
            $display("FAIL %s: data %0d expected %0d", it.tag, out_data, it.val);
          end
          checks++;
          if (cyc - it.stamp != LAT) begin
            errors++;
            $display("FAIL R3: latency %0d expected %0d", cyc - it.stamp, LAT);
          end
        end
      end else begin
        checks++;
        if (out_data !== last_out) begin
          errors++;
          $display("FAIL R6: idle output %0d expected %0d", out_data, last_out);
        end
      end
      last_out = out_data;
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: valid=%b data=%0d expected valid=0 data=0", out_valid, out_data);
    end
    rst = 1'b0;

    // R1: first results see zero history
    push(100, "R1");
    push(-3, "R1");
    idle(4);

    // R8: impulse gives taps in order
    push(1, "R8");
    for (int i = 0; i < 4; i++) push(0, "R8");
    idle(3);

    // R7 / R9: full scale, back to back
    for (int i = 0; i < 4; i++) push(2047, "R7");
    for (int i = 0; i < 4; i++) push(-2048, "R7");
    for (int i = 0; i < 8; i++) push((i % 2) ? -2048 : 2047, "R9");

    // R5: gaps with junk must not advance history
    push(5, "R5");
    idle(3);
    push(-7, "R5");
    idle(1);
    push(9, "R5");
    idle(6);
    push(11, "R5");

    // R2: random samples with random gaps
    for (int i = 0; i < 300; i++) begin
      push($signed(IW'($urandom)), "R2");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end

    idle(LAT + 6);

    // R4: one output per accepted sample
    checks++;
    if (sb.size() != 0 || n_out != n_in) begin
      errors++;
      $display("FAIL R4: outputs %0d expected %0d", n_out, n_in);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule